// File: doc/BRIEF.md
# Start-Restartable Two-Wire Slave Byte Engine

This block is the byte-level shift engine of a two-wire (I2C) slave. The bus master supplies SCL, so the engine shifts on that clock. The block samples the already-synchronised SCL and SDA levels on its own system clock. It finds SCL edges and bus start and stop conditions, and then moves one byte per nine-clock frame. Eight data bits go out and come in MSB first. Outgoing data changes on SCL falling edges and incoming data is sampled on SCL rising edges. The ninth clock is the acknowledge slot.

When restart-on-start is enabled, a start condition rebuilds the frame at once. The transmit shifter is refilled from the holding register, the receive shifter is cleared and the bit count goes back to zero, so the next SCL clock is bit 1. The start also arms the wait bit, which stretches SCL low from the falling edge that ends the acknowledge clock until software clears the bit. The buffer-empty flag is left alone when a transfer is started this way. Data transfers continue after each frame without restart: the holding register refills the shifter at each frame end.

The engine drives both lines as open-drain pull-downs. An enable output of 1 means the pin is pulled low. Software can make SDA high impedance at any time.

Top module: `i2cs_engine`

## Requirements
- R1: After reset, SDA and SCL pull-downs are off, the received byte is 0, rx_done_o is 0 and tx_empty_o is 1.
- R2: Outgoing data leaves MSB first. The current transmit bit appears on the SDA pull-down (1 when the bit is 0) in the system clock cycle after each SCL falling edge of data bits 1 to 8. At the falling edge that ends a frame, the shifter reloads from the holding register and bit 1 of the new byte appears.
- R3: After a start condition (SDA falling while SCL is high), the SDA output keeps its previous value until the first SCL falling edge that follows.
- R4: With start_init_en_i at 1, a start condition clears the receive shifter and restarts the bit count, even in the middle of a byte. The next SCL rising edge then samples bit 1.
- R5: A start condition with start_init_en_i at 1 sets the wait bit. While the wait bit is 1, the SCL pull-down turns on at the SCL falling edge after the ninth rising edge, and stays on.
- R6: A pulse on wait_clr_i clears the wait bit and turns the SCL pull-down off one cycle later. With the wait bit at 0, a frame end leaves SCL released.
- R7: tx_load_i writes the holding register and clears tx_empty_o. A start-triggered reload leaves tx_empty_o unchanged. A frame-end reload sets tx_empty_o.
- R8: While sda_dis_i is 1, the SDA pull-down is off whatever the shift data.
- R9: On the ninth SCL rising edge, the eight sampled data bits (first-sampled bit in bit 7) appear on rx_data_o. rx_done_o is high for exactly that one cycle.
- R10: A stop condition (SDA rising while SCL is high) releases SDA and returns the engine to idle. In idle, SCL edges move no data and raise no rx_done_o.
- R11: With start_init_en_i at 0, a start condition while idle is ignored: the following clocks produce no rx_done_o and no SCL hold.
- R12: During the acknowledge (ninth) clock, the engine's own SDA output is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised SCL bus level |
| sda_i | input | 1 | Synchronised SDA bus level |
| tx_data_i | input | DATA_W | Byte for the transmit holding register |
| tx_load_i | input | 1 | Write pulse for the holding register |
| start_init_en_i | input | 1 | Restart both shifters on a start condition |
| wait_set_i | input | 1 | Software pulse that sets the wait bit |
| wait_clr_i | input | 1 | Software pulse that clears the wait bit and releases SCL |
| sda_dis_i | input | 1 | Force SDA to high impedance |
| sda_oe_o | output | 1 | SDA pull-down enable |
| scl_oe_o | output | 1 | SCL pull-down enable |
| rx_data_o | output | DATA_W | Last received byte |
| rx_done_o | output | 1 | One-cycle pulse at the ninth rising edge |
| tx_empty_o | output | 1 | Transmit holding register consumed |

## Verification
The bench builds the engine with the default DATA_W of 8, so each frame is eight data bits plus the acknowledge clock. At that width a nine-clock frame takes about a hundred system cycles. This leaves room for several full frames, a restart in the middle of a byte, a stretched frame end, a stop and idle-time clocking within one short run. Master data are chosen so the wired-AND bus carries known bytes, such as 5A with a leading zero, which makes a too-early SDA change after a start visible.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    typedef struct packed {
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } bus_ev_t;

    typedef enum logic [2:0] {
        TXOP_NONE,
        TXOP_RELOAD,
        TXOP_SHIFT,
        TXOP_RELEASE,
        TXOP_NEXT
    } tx_op_t;

    typedef enum logic [1:0] {
        RXOP_NONE,
        RXOP_CLEAR,
        RXOP_SAMPLE,
        RXOP_LATCH
    } rx_op_t;

endpackage

// File: rtl/i2cs_bus_events.sv
module i2cs_bus_events
    import i2cs_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev_o
);

    typedef struct packed {
        logic scl;
        logic sda;
    } lvl_t;

    lvl_t lvl_d, lvl_q;

    always_comb begin
        lvl_d     = lvl_q;
        lvl_d.scl = scl_i;
        lvl_d.sda = sda_i;

        ev_o.rise  = !lvl_q.scl &&  scl_i;
        ev_o.fall  =  lvl_q.scl && !scl_i;
        ev_o.start =  lvl_q.scl &&  scl_i &&  lvl_q.sda && !sda_i;
        ev_o.stop  =  lvl_q.scl &&  scl_i && !lvl_q.sda &&  sda_i;
    end

    // Bus idles high, so reset to high to avoid a false edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= '{scl: 1'b1, sda: 1'b1};
        end else begin
            lvl_q <= lvl_d;
        end
    end

endmodule

// File: rtl/i2cs_tx_shift.sv
module i2cs_tx_shift
    import i2cs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tx_op_t            op_i,
    input  logic [DATA_W-1:0] fill_i,
    output logic              bit_o
);

    localparam int MSB = DATA_W - 1;

    typedef struct packed {
        logic [DATA_W-1:0] sh;
        logic              out;
    } tx_st_t;

    tx_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (op_i)
            TXOP_RELOAD: begin
                // Refill only; the line keeps its present level.
                st_d.sh = fill_i;
            end
            TXOP_SHIFT: begin
                st_d.out = st_q.sh[MSB];
                st_d.sh  = {st_q.sh[MSB-1:0], 1'b1};
            end
            TXOP_RELEASE: begin
                st_d.out = 1'b1;
            end
            TXOP_NEXT: begin
                st_d.out = fill_i[MSB];
                st_d.sh  = {fill_i[MSB-1:0], 1'b1};
            end
            default: begin
                st_d = st_q;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sh: '0, out: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_o = st_q.out;

endmodule

// File: rtl/i2cs_rx_shift.sv
module i2cs_rx_shift
    import i2cs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rx_op_t            op_i,
    input  logic              sda_i,
    output logic [DATA_W-1:0] data_o,
    output logic              done_o
);

    typedef struct packed {
        logic [DATA_W-1:0] sh;
        logic [DATA_W-1:0] data;
        logic              done;
    } rx_st_t;

    rx_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (op_i)
            RXOP_CLEAR:  st_d.sh = '0;
            RXOP_SAMPLE: st_d.sh = {st_q.sh[DATA_W-2:0], sda_i};
            RXOP_LATCH: begin
                st_d.data = st_q.sh;
                st_d.done = 1'b1;
            end
            default: st_d.sh = st_q.sh;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sh: '0, data: '0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o = st_q.data;
    assign done_o = st_q.done;

endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
    import i2cs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              tx_load_i,
    input  logic              start_init_en_i,
    input  logic              wait_set_i,
    input  logic              wait_clr_i,
    input  logic              sda_dis_i,
    output logic              sda_oe_o,
    output logic              scl_oe_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_done_o,
    output logic              tx_empty_o
);

    localparam int              CNT_W     = $clog2(DATA_W + 2);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    typedef struct packed {
        logic              active;
        logic [CNT_W-1:0]  cnt;       // rising edges seen in this frame
        logic              wait_bit;
        logic              scl_hold;
        logic              empty;
        logic [DATA_W-1:0] hold_reg;
    } ctl_t;

    ctl_t    st_d, st_q;
    bus_ev_t ev;
    tx_op_t  tx_op;
    rx_op_t  rx_op;
    logic    tx_bit;
    logic    restart;

    i2cs_bus_events u_events (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    always_comb begin
        st_d    = st_q;
        tx_op   = TXOP_NONE;
        rx_op   = RXOP_NONE;
        restart = ev.start && start_init_en_i;

        if (restart) begin
            st_d.active   = 1'b1;
            st_d.cnt      = '0;
            st_d.wait_bit = 1'b1;
            tx_op         = TXOP_RELOAD;
            rx_op         = RXOP_CLEAR;
        end else if (st_q.active) begin
            if (ev.stop) begin
                st_d.active = 1'b0;
                st_d.cnt    = '0;
                tx_op       = TXOP_RELEASE;
            end else if (ev.rise) begin
                if (st_q.cnt < LAST_BIT) begin
                    rx_op    = RXOP_SAMPLE;
                    st_d.cnt = st_q.cnt + CNT_ONE;
                end else if (st_q.cnt == LAST_BIT) begin
                    rx_op    = RXOP_LATCH;
                    st_d.cnt = st_q.cnt + CNT_ONE;
                end
            end else if (ev.fall) begin
                if (st_q.cnt < LAST_BIT) begin
                    tx_op = TXOP_SHIFT;
                end else if (st_q.cnt == LAST_BIT) begin
                    tx_op = TXOP_RELEASE;
                end else begin
                    tx_op      = TXOP_NEXT;
                    st_d.cnt   = '0;
                    st_d.empty = 1'b1;
                    if (st_q.wait_bit) begin
                        st_d.scl_hold = 1'b1;
                    end
                end
            end
        end

        if (!restart) begin
            if (wait_set_i) begin
                st_d.wait_bit = 1'b1;
            end
            if (wait_clr_i) begin
                st_d.wait_bit = 1'b0;
                st_d.scl_hold = 1'b0;
            end
        end

        if (tx_load_i) begin
            st_d.hold_reg = tx_data_i;
            st_d.empty    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{active: 1'b0, cnt: '0, wait_bit: 1'b0, scl_hold: 1'b0,
                      empty: 1'b1, hold_reg: '0};
        end else begin
            st_q <= st_d;
        end
    end

    i2cs_tx_shift #(.DATA_W(DATA_W)) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .op_i   (tx_op),
        .fill_i (st_q.hold_reg),
        .bit_o  (tx_bit)
    );

    i2cs_rx_shift #(.DATA_W(DATA_W)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .op_i   (rx_op),
        .sda_i  (sda_i),
        .data_o (rx_data_o),
        .done_o (rx_done_o)
    );

    assign sda_oe_o   = !sda_dis_i && !tx_bit;
    assign scl_oe_o   = st_q.scl_hold;
    assign tx_empty_o = st_q.empty;

endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker
    import i2cs_pkg::*;
(
    input logic    clk,
    input logic    rst_n,
    input bus_ev_t ev_i,
    input logic    start_en_i,
    input logic    active_i,
    input logic    tx_bit_i,
    input logic    tx_load_i,
    input logic    wait_clr_i,
    input logic    sda_dis_i,
    input logic    sda_oe_i,
    input logic    scl_oe_i,
    input logic    rx_done_i,
    input logic    tx_empty_i
);

    a_r3_sda_kept_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        ev_i.start && start_en_i |=> $stable(tx_bit_i));

    a_r5_hold_only_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe_i) |-> $past(ev_i.fall));

    a_r6_release_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
        wait_clr_i && !(ev_i.start && start_en_i) |=> !scl_oe_i);

    a_r7_empty_kept_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        ev_i.start && start_en_i && !tx_load_i |=> tx_empty_i == $past(tx_empty_i));

    a_r8_sda_forced_off: assert property (@(posedge clk) disable iff (!rst_n)
        sda_dis_i |-> !sda_oe_i);

    a_r9_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done_i |=> !rx_done_i);

    a_r10_done_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_done_i) |-> $past(active_i));

endmodule

bind i2cs_engine i2cs_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_i       (ev),
    .start_en_i (start_init_en_i),
    .active_i   (st_q.active),
    .tx_bit_i   (tx_bit),
    .tx_load_i  (tx_load_i),
    .wait_clr_i (wait_clr_i),
    .sda_dis_i  (sda_dis_i),
    .sda_oe_i   (sda_oe_o),
    .scl_oe_i   (scl_oe_o),
    .rx_done_i  (rx_done_o),
    .tx_empty_i (tx_empty_o)
);

// File: tb/sim_i2cs_engine.sv
module sim_i2cs_engine;

    localparam int CLK_P = 10;
    localparam int W     = 8;
    localparam int HALF  = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         m_scl = 1'b1;
    logic         m_sda = 1'b1;
    logic [W-1:0] tx_data = '0;
    logic         tx_load = 1'b0;
    logic         start_en = 1'b0;
    logic         wait_set = 1'b0;
    logic         wait_clr = 1'b0;
    logic         sda_dis = 1'b0;
    logic         sda_oe, scl_oe, rx_done, tx_empty;
    logic [W-1:0] rx_data;
    wire          scl_bus = m_scl & ~scl_oe;
    wire          sda_bus = m_sda & ~sda_oe;

    int checks = 0;
    int fails = 0;
    int done_cnt = 0;
    bit finished = 0;

    i2cs_engine #(.DATA_W(W)) u0 (
        .clk             (clk),
        .rst_n           (rst_n),
        .scl_i           (scl_bus),
        .sda_i           (sda_bus),
        .tx_data_i       (tx_data),
        .tx_load_i       (tx_load),
        .start_init_en_i (start_en),
        .wait_set_i      (wait_set),
        .wait_clr_i      (wait_clr),
        .sda_dis_i       (sda_dis),
        .sda_oe_o        (sda_oe),
        .scl_oe_o        (scl_oe),
        .rx_data_o       (rx_data),
        .rx_done_o       (rx_done),
        .tx_empty_o      (tx_empty)
    );

    always #(CLK_P/2) clk = ~clk;

    // Behavioural reference model
    bit     pv_scl, pv_sda, m_act, m_out, m_wait, m_hold, m_empty, m_done;
    int     m_rises, m_rx, m_rxdata, m_holdreg;
    bit     txq[$];

    function automatic void refill();
        txq.delete();
        for (int i = W - 1; i >= 0; i--) txq.push_back(m_holdreg[i]);
    endfunction

    function automatic bit pop_bit();
        if (txq.size() > 0) return txq.pop_front();
        return 1'b1;
    endfunction

    always @(posedge clk) begin : ref_model
        bit s, d, st, sp, ri, fa, rs;
        if (!rst_n) begin
            pv_scl = 1; pv_sda = 1; m_act = 0; m_out = 1; m_wait = 0;
            m_hold = 0; m_empty = 1; m_done = 0; m_rises = 0; m_rx = 0;
            m_rxdata = 0; m_holdreg = 0; txq.delete();
        end else begin
            s  = scl_bus;
            d  = sda_bus;
            st = pv_scl && s && pv_sda && !d;
            sp = pv_scl && s && !pv_sda && d;
            ri = !pv_scl && s;
            fa = pv_scl && !s;
            m_done = 0;
            rs = st && start_en;
            if (rs) begin
                m_act = 1; m_rises = 0; refill(); m_rx = 0; m_wait = 1;
            end else if (m_act) begin
                if (sp) begin
                    m_act = 0; m_rises = 0; m_out = 1;
                end else if (ri) begin
                    if (m_rises < W) m_rx = ((m_rx << 1) | int'(d)) & ((1 << W) - 1);
                    else if (m_rises == W) begin m_rxdata = m_rx; m_done = 1; end
                    if (m_rises <= W) m_rises++;
                end else if (fa) begin
                    if (m_rises < W) m_out = pop_bit();
                    else if (m_rises == W) m_out = 1;
                    else begin
                        refill(); m_out = pop_bit(); m_empty = 1;
                        if (m_wait) m_hold = 1;
                        m_rises = 0;
                    end
                end
            end
            if (!rs) begin
                if (wait_set) m_wait = 1;
                if (wait_clr) begin m_wait = 0; m_hold = 0; end
            end
            if (tx_load) begin m_holdreg = int'(tx_data); m_empty = 0; end
            pv_scl = s;
            pv_sda = d;
        end
    end

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (rx_done) done_cnt++;
            chk("R2", int'(sda_oe), int'(!sda_dis && !m_out), "sda_oe vs model");
            chk("R5", int'(scl_oe), int'(m_hold), "scl_oe vs model");
            chk("R9", int'(rx_data), m_rxdata, "rx_data vs model");
            chk("R9", int'(rx_done), int'(m_done), "rx_done vs model");
            chk("R7", int'(tx_empty), int'(m_empty), "tx_empty vs model");
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic clk_bit(input logic b);
        m_sda = b;  step(HALF);
        m_scl = 1;  step(HALF);
        m_scl = 0;  step(HALF);
    endtask

    task automatic send_bits(input logic [W-1:0] v, input int n);
        for (int i = W - 1; i >= W - n; i--) clk_bit(v[i]);
    endtask

    task automatic bus_start();
        m_sda = 1; step(HALF);
        m_scl = 1; step(HALF);
        m_sda = 0; step(HALF);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        step(3);
        rst_n = 1;
        step(1);
        // R1 reset state
        chk("R1", int'(sda_oe), 0, "sda_oe after reset");
        chk("R1", int'(scl_oe), 0, "scl_oe after reset");
        chk("R1", int'(tx_empty), 1, "tx_empty after reset");
        chk("R1", int'(rx_data), 0, "rx_data after reset");
        chk("R1", int'(rx_done), 0, "rx_done after reset");

        // Frame 1: restart-triggered transmit of 5A
        start_en = 1;
        tx_data = 8'h5A; tx_load = 1; step(1); tx_load = 0;
        chk("R7", int'(tx_empty), 0, "empty cleared by load");
        bus_start();
        chk("R3", int'(sda_oe), 0, "SDA unchanged after start");
        chk("R7", int'(tx_empty), 0, "empty untouched by start");
        m_scl = 0; step(HALF);
        chk("R2", int'(sda_oe), 1, "bit1 of 5A drives low");
        send_bits(8'hFF, 8);
        m_sda = 0; step(HALF);
        m_scl = 1; step(HALF);
        chk("R12", int'(sda_oe), 0, "SDA released in ack slot");
        chk("R9", int'(rx_data), 32'h5A, "received byte frame 1");
        m_scl = 0; step(HALF);
        chk("R5", int'(scl_oe), 1, "SCL held after ninth fall");
        chk("R7", int'(tx_empty), 1, "empty set by frame-end reload");
        m_scl = 1; step(HALF);
        chk("R5", int'(scl_bus), 0, "bus SCL stays low while held");
        m_scl = 0; step(1);
        wait_clr = 1; step(1); wait_clr = 0;
        chk("R6", int'(scl_oe), 0, "SCL released by clear");

        // Frame 2: SDA disabled, master sends 3C, no hold
        sda_dis = 1; step(1);
        chk("R8", int'(sda_oe), 0, "SDA off while disabled");
        send_bits(8'h3C, 8);
        clk_bit(1'b1);
        chk("R9", int'(rx_data), 32'h3C, "received byte frame 2");
        chk("R6", int'(scl_oe), 0, "no hold with wait cleared");
        chk("R9", done_cnt, 2, "done pulses after frame 2");

        // Frame 3: three bits then restart mid-byte
        send_bits(8'hA0, 3);
        bus_start();
        m_scl = 0; step(HALF);
        send_bits(8'h96, 8);
        clk_bit(1'b0);
        chk("R4", int'(rx_data), 32'h96, "byte after mid-byte restart");
        chk("R5", int'(scl_oe), 1, "restart re-armed wait hold");
        wait_clr = 1; step(1); wait_clr = 0;

        // Stop, then idle clocks
        m_sda = 0; step(HALF);
        m_scl = 1; step(HALF);
        m_sda = 1; step(HALF);
        sda_dis = 0; step(1);
        chk("R10", int'(sda_oe), 0, "SDA released after stop");
        m_scl = 0; step(HALF);
        send_bits(8'h00, 8);
        clk_bit(1'b0);
        chk("R10", done_cnt, 3, "no receive while idle");
        chk("R10", int'(sda_oe), 0, "SDA quiet while idle");

        // Start ignored when restart disabled
        start_en = 0;
        bus_start();
        m_scl = 0; step(HALF);
        send_bits(8'h81, 8);
        clk_bit(1'b0);
        chk("R11", done_cnt, 3, "no receive after ignored start");
        chk("R11", int'(scl_oe), 0, "no hold after ignored start");

        tx_data = 8'hC3; tx_load = 1; step(1); tx_load = 0;
        chk("R7", int'(tx_empty), 0, "empty cleared by second load");
        step(2);
        finish_run();
    end

endmodule